// File: doc/BRIEF.md
# Compressed Immediate Field Expander

This block sits in the decode stage of a processor that accepts 16-bit compressed instructions next to its normal 32-bit stream. It takes one 16-bit word from the immediate-carrying group of the compressed encoding. It works out which operation the word names: add-immediate, shifted add-immediate, doubleword or word compare-immediate, a load or store based on the stack pointer, or a load or store based on a register. It then turns the scattered immediate bits into a signed 64-bit operand. That operand is sign extended, scaled to the access size and, for the stack-pointer forms, biased. The block also supplies the destination or data register and the implied base register.

The operand is ready to go straight to the adder or the address generator. Encodings that are still unassigned raise a reserved flag. Words that cannot belong to this group at all raise an error flag. Every output is registered. A word presented with `valid_i` high appears on the outputs one clock later, and the outputs keep their value while no new word arrives.

Bit numbering is LSB-first: `instr_i[15]` and `instr_i[0]` are the two mode bits, `instr_i[14:11]` is the upper field `h`, `instr_i[10:8]` is the major code, `instr_i[7]` is the minor bit, `instr_i[6:4]` is field `fa` and `instr_i[3:1]` is field `fb`. "sext(n)" means the value is read as an n-bit two's-complement number.

Top module: `cimm_expander`

## Requirements
- R1: During reset and until the first valid word, `vld_o`, `err_o` and `rsv_o` are 0, and `op_o`, `imm_o`, `rd_o` and `ra_o` are all zero. Operation code 0 means no operation.
- R2: When a word is presented with `valid_i`=1 at a rising edge, its results appear on every output after that edge. `vld_o` equals `valid_i` from the previous edge.
- R3: While `valid_i`=0, `op_o`, `imm_o`, `rd_o`, `ra_o`, `err_o` and `rsv_o` keep their previous values and `vld_o` is 0.
- R4: A word with `instr_i[15]`=0, or `instr_i[0]`=0, or major.minor = 001.1, sets `err_o`=1 and `rsv_o`=0. It gives operation 0, a zero immediate and zero registers.
- R5: Major.minor 010.0 with `fa`≠0 is add-immediate (code 1). Here `rd_o`=`ra_o`=`fa` and the immediate is sext(4) of {`instr_i[11]`,`fb`}, giving -8..+7. Bits 14:12 are ignored.
- R6: Major.minor 001.0 with `instr_i[14:13]`=11 and `fa`≠0 is the shifted add-immediate (code 2). Here `rd_o`=`ra_o`=`fa` and the immediate is sext(5) of {`instr_i[12:11]`,`fb`} times 8, giving -128..+120 in steps of 8.
- R7: These words set `rsv_o`=1 with `err_o`=0, operation 0, a zero immediate and zero registers: any 000.x word; any 001.0 word whose `instr_i[14:13]` is not 11; and any R5 or R6 pattern with `fa`=0.
- R8: Major.minor 010.1 is compare-immediate. It is doubleword (code 3) when `instr_i[14]`=0 and word (code 4) otherwise. Here `ra_o`=`fa`, `rd_o`=0, and the immediate is sext(6) of {`instr_i[13:11]`,`fb`}, unscaled.
- R9: Major 011 is a stack-pointer access. It is a load for minor 0 and a store for minor 1. The access is doubleword when `instr_i[14]`=0 and word otherwise, giving codes 5 (load dword), 6 (load word), 7 (store dword) and 8 (store word). Here `ra_o`=1 and `rd_o`=`fa`. The immediate is sext(6) of {`instr_i[13:11]`,`fb`}, scaled by the access size, minus 256.
- R10: Majors 100 to 111 are register-based accesses with `ra_o`=`instr_i[13:11]` and `rd_o`=`fa`. The immediate is sext(4) of {`instr_i[14]`,`fb`}, scaled by the access size. Codes by major.minor: 100.0 store word 12, 100.1 store dword 11, 101.0 load dword 9, 101.1 load word 10, 110.0 store single 15, 110.1 store double 16, 111.0 load single 13, 111.1 load double 14.
- R11: Every 8-byte access (codes 5, 7, 9, 11, 14, 16) scales its offset by 8. Every 4-byte access (codes 6, 8, 10, 12, 13, 15) scales its offset by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `instr_i` |
| instr_i | input | 16 | Compressed immediate-group word |
| vld_o | output | 1 | Outputs hold a freshly expanded word |
| op_o | output | 5 | Operation code |
| imm_o | output | 64 | Expanded signed operand |
| rd_o | output | 5 | Destination or data register |
| ra_o | output | 5 | Source or base register |
| err_o | output | 1 | Word is outside the immediate group |
| rsv_o | output | 1 | Word is an unassigned encoding |

## Verification
A decode fault in this block shows up at the ports in the cycle right after the offending word is accepted. It appears as a wrong operation code, a wrong register, or an operand off by a scale factor, a bias or a sign bit. A fault in the enable of the output stage shows up one idle cycle later, when held values drift. For that reason every one of the 65,536 possible words is pushed through back to back and compared against an arithmetic model, and the idle hold is checked separately. A wrong sign extension width is most visible at the edges of each field: the most negative value, -1 and the largest positive value. The sweep covers all of these.

// File: rtl/cimm_pkg.sv
package cimm_pkg;

  typedef enum logic [4:0] {
    OP_NONE   = 5'd0,
    OP_ADDI   = 5'd1,
    OP_ADDIS  = 5'd2,
    OP_CMPD   = 5'd3,
    OP_CMPW   = 5'd4,
    OP_LD_SP  = 5'd5,
    OP_LW_SP  = 5'd6,
    OP_STD_SP = 5'd7,
    OP_STW_SP = 5'd8,
    OP_LD     = 5'd9,
    OP_LW     = 5'd10,
    OP_STD    = 5'd11,
    OP_STW    = 5'd12,
    OP_LFS    = 5'd13,
    OP_LFD    = 5'd14,
    OP_STFS   = 5'd15,
    OP_STFD   = 5'd16
  } cimm_op_e;

  typedef enum logic [1:0] {
    SC_X1 = 2'd0,
    SC_X4 = 2'd1,
    SC_X8 = 2'd2
  } cimm_scale_e;

  typedef struct packed {
    cimm_op_e    op;
    logic [5:0]  raw;     // immediate bits, right aligned
    logic [2:0]  raw_w;   // significant bits in raw (4..6)
    cimm_scale_e scale;
    logic        sp_form; // stack-pointer base and bias
    logic [2:0]  rd;
    logic [2:0]  ra;
    logic        err;
    logic        rsv;
  } cimm_dec_t;

endpackage

// File: rtl/cimm_decode.sv
module cimm_decode
  import cimm_pkg::*;
(
  input  logic [15:0] instr_i,
  output cimm_dec_t   dec_o
);

  logic [2:0] maj, fa, fb;
  logic       mnr;

  assign maj = instr_i[10:8];
  assign mnr = instr_i[7];
  assign fa  = instr_i[6:4];
  assign fb  = instr_i[3:1];

  always_comb begin
    dec_o         = '0;
    dec_o.op      = OP_NONE;
    dec_o.raw_w   = 3'd4;
    dec_o.scale   = SC_X1;
    if (!instr_i[15] || !instr_i[0] || {maj, mnr} == 4'b0011) begin
      dec_o.err = 1'b1;
    end else begin
      unique case (maj)
        3'b000: dec_o.rsv = 1'b1;
        3'b001: begin
          if (instr_i[14:13] == 2'b11 && fa != 3'd0) begin
            dec_o.op    = OP_ADDIS;
            dec_o.raw   = {1'b0, instr_i[12:11], fb};
            dec_o.raw_w = 3'd5;
            dec_o.scale = SC_X8;
            dec_o.rd    = fa;
            dec_o.ra    = fa;
          end else begin
            dec_o.rsv = 1'b1;
          end
        end
        3'b010: begin
          if (mnr) begin
            dec_o.op    = instr_i[14] ? OP_CMPW : OP_CMPD;
            dec_o.raw   = {instr_i[13:11], fb};
            dec_o.raw_w = 3'd6;
            dec_o.ra    = fa;
          end else if (fa != 3'd0) begin
            dec_o.op    = OP_ADDI;
            dec_o.raw   = {2'b00, instr_i[11], fb};
            dec_o.rd    = fa;
            dec_o.ra    = fa;
          end else begin
            dec_o.rsv = 1'b1;
          end
        end
        3'b011: begin
          if (mnr) dec_o.op = instr_i[14] ? OP_STW_SP : OP_STD_SP;
          else     dec_o.op = instr_i[14] ? OP_LW_SP  : OP_LD_SP;
          dec_o.raw     = {instr_i[13:11], fb};
          dec_o.raw_w   = 3'd6;
          dec_o.scale   = instr_i[14] ? SC_X4 : SC_X8;
          dec_o.sp_form = 1'b1;
          dec_o.rd      = fa;
        end
        default: begin
          unique case ({maj[1:0], mnr})
            3'b000:  begin dec_o.op = OP_STW;  dec_o.scale = SC_X4; end
            3'b001:  begin dec_o.op = OP_STD;  dec_o.scale = SC_X8; end
            3'b010:  begin dec_o.op = OP_LD;   dec_o.scale = SC_X8; end
            3'b011:  begin dec_o.op = OP_LW;   dec_o.scale = SC_X4; end
            3'b100:  begin dec_o.op = OP_STFS; dec_o.scale = SC_X4; end
            3'b101:  begin dec_o.op = OP_STFD; dec_o.scale = SC_X8; end
            3'b110:  begin dec_o.op = OP_LFS;  dec_o.scale = SC_X4; end
            default: begin dec_o.op = OP_LFD;  dec_o.scale = SC_X8; end
          endcase
          dec_o.raw = {2'b00, instr_i[14], fb};
          dec_o.rd  = fa;
          dec_o.ra  = instr_i[13:11];
        end
      endcase
    end
  end

endmodule

// File: rtl/cimm_imm_gen.sv
module cimm_imm_gen
  import cimm_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int SP_BIAS = 256
) (
  input  logic [5:0]      raw_i,
  input  logic [2:0]      raw_w_i,
  input  cimm_scale_e     scale_i,
  input  logic            sp_i,
  output logic [XLEN-1:0] imm_o
);

  localparam int RAW_W = 6;
  localparam logic [XLEN-1:0] BIAS = XLEN'(SP_BIAS);

  logic [2:0]            pad;
  logic [RAW_W-1:0]      top;
  logic signed [RAW_W-1:0] sx;
  logic [XLEN-1:0]       ext, scaled;

  // left-justify, then arithmetic shift back to extend from raw_w bits
  assign pad = 3'(RAW_W) - raw_w_i;
  assign top = raw_i << pad;
  assign sx  = $signed(top) >>> pad;
  assign ext = {{(XLEN-RAW_W){sx[RAW_W-1]}}, sx};

  always_comb begin
    unique case (scale_i)
      SC_X4:   scaled = ext << 2;
      SC_X8:   scaled = ext << 3;
      default: scaled = ext;
    endcase
  end

  assign imm_o = sp_i ? scaled - BIAS : scaled;

endmodule

// File: rtl/cimm_out_reg.sv
module cimm_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= en_i;
      if (en_i) q_o <= d_i;
    end
  end

endmodule

// File: rtl/cimm_expander.sv
module cimm_expander
  import cimm_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int REG_W   = 5,
  parameter int SP_REG  = 1,
  parameter int SP_BIAS = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [15:0]      instr_i,
  output logic             vld_o,
  output logic [4:0]       op_o,
  output logic [XLEN-1:0]  imm_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] ra_o,
  output logic             err_o,
  output logic             rsv_o
);

  localparam int OP_W = $bits(cimm_op_e);
  localparam int PW   = OP_W + XLEN + 2 * REG_W + 2;

  cimm_dec_t        dec;
  logic [XLEN-1:0]  imm_d;
  logic [REG_W-1:0] ra_d;
  logic [PW-1:0]    pay_d, pay_q;

  cimm_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  cimm_imm_gen #(
    .XLEN    (XLEN),
    .SP_BIAS (SP_BIAS)
  ) u_imm (
    .raw_i   (dec.raw),
    .raw_w_i (dec.raw_w),
    .scale_i (dec.scale),
    .sp_i    (dec.sp_form),
    .imm_o   (imm_d)
  );

  assign ra_d  = dec.sp_form ? REG_W'(SP_REG) : REG_W'(dec.ra);
  assign pay_d = {dec.op, imm_d, REG_W'(dec.rd), ra_d, dec.err, dec.rsv};

  cimm_out_reg #(
    .W (PW)
  ) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .d_i    (pay_d),
    .vld_o  (vld_o),
    .q_o    (pay_q)
  );

  assign {op_o, imm_o, rd_o, ra_o, err_o, rsv_o} = pay_q;

endmodule

// File: rtl/cimm_expander_chk.sv
module cimm_expander_chk
  import cimm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            vld_o,
  input logic [4:0]      op_o,
  input logic [XLEN-1:0] imm_o,
  input logic            err_o,
  input logic            rsv_o
);

  logic started;
  logic is_dw, is_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  assign is_dw = op_o inside {5'd5, 5'd7, 5'd9, 5'd11, 5'd14, 5'd16};
  assign is_w  = op_o inside {5'd6, 5'd8, 5'd10, 5'd12, 5'd13, 5'd15};

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> (vld_o == $past(valid_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !$past(valid_i)) |-> ($stable(imm_o) && $stable(op_o)));

  p_err_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (op_o == 5'd0 && imm_o == '0 && !rsv_o));

  p_rsv_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_o |-> (op_o == 5'd0 && imm_o == '0 && !err_o));

  p_addi_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 5'(OP_ADDI)) |-> ($signed(imm_o) >= -8 && $signed(imm_o) <= 7));

  p_addis_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 5'(OP_ADDIS)) |-> (imm_o[2:0] == 3'b000));

  p_sp_neg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o inside {5'd5, 5'd6, 5'd7, 5'd8}) |-> imm_o[XLEN-1]);

  p_dw_align_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dw |-> (imm_o[2:0] == 3'b000));

  p_w_align_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_w |-> (imm_o[1:0] == 2'b00));

endmodule

bind cimm_expander cimm_expander_chk #(.XLEN(XLEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .vld_o   (vld_o),
  .op_o    (op_o),
  .imm_o   (imm_o),
  .err_o   (err_o),
  .rsv_o   (rsv_o)
);

// File: tb/cimm_expander_test.sv
module cimm_expander_test;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        vld_o, err_o, rsv_o;
  logic [4:0]  op_o, rd_o, ra_o;
  logic [63:0] imm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  cimm_expander uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .instr_i (instr_i),
    .vld_o   (vld_o),
    .op_o    (op_o),
    .imm_o   (imm_o),
    .rd_o    (rd_o),
    .ra_o    (ra_o),
    .err_o   (err_o),
    .rsv_o   (rsv_o)
  );

  function automatic longint sx(input int v, input int n);
    longint r = longint'(v);
    if (v >= (1 << (n - 1))) r = r - (longint'(1) << n);
    return r;
  endfunction

  function automatic void model(input int w, output int op, output longint imm,
                                output int rd, output int ra, output bit err,
                                output bit rsv, output string tag);
    int fa  = (w >> 4) & 7;
    int fb  = (w >> 1) & 7;
    int maj = (w >> 8) & 7;
    int mn  = (w >> 7) & 1;
    int b14 = (w >> 14) & 1;
    int sc;
    int ops[8]   = '{12, 11, 9, 10, 15, 16, 13, 14};
    int scs[8]   = '{4, 8, 8, 4, 4, 8, 4, 8};
    op = 0; imm = 0; rd = 0; ra = 0; err = 0; rsv = 0;
    if (((w >> 15) & 1) == 0 || (w & 1) == 0 || (maj == 1 && mn == 1)) begin
      err = 1; tag = "R4";
    end else if (maj == 0) begin
      rsv = 1; tag = "R7";
    end else if (maj == 1) begin
      if (((w >> 13) & 3) == 3 && fa != 0) begin
        op = 2; imm = sx(((w >> 11) & 3) * 8 + fb, 5) * 8; rd = fa; ra = fa; tag = "R6";
      end else begin
        rsv = 1; tag = "R7";
      end
    end else if (maj == 2 && mn == 0) begin
      if (fa != 0) begin
        op = 1; imm = sx(((w >> 11) & 1) * 8 + fb, 4); rd = fa; ra = fa; tag = "R5";
      end else begin
        rsv = 1; tag = "R7";
      end
    end else if (maj == 2) begin
      op = b14 ? 4 : 3; imm = sx(((w >> 11) & 7) * 8 + fb, 6); ra = fa; tag = "R8";
    end else if (maj == 3) begin
      sc = b14 ? 4 : 8;
      op = mn ? (b14 ? 8 : 7) : (b14 ? 6 : 5);
      imm = sx(((w >> 11) & 7) * 8 + fb, 6) * sc - 256; rd = fa; ra = 1; tag = "R9 R11";
    end else begin
      op = ops[(maj - 4) * 2 + mn]; sc = scs[(maj - 4) * 2 + mn];
      imm = sx(b14 * 8 + fb, 4) * sc; rd = fa; ra = (w >> 11) & 7; tag = "R10 R11";
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic chk_word(input int w);
    int op, rd, ra; longint imm; bit err, rsv; string tag;
    model(w, op, imm, rd, ra, err, rsv, tag);
    chk(vld_o && int'(op_o) == op && $signed(imm_o) == imm && int'(rd_o) == rd &&
        int'(ra_o) == ra && err_o == err && rsv_o == rsv, {tag, " R2"},
        $sformatf("w=%h act vld=%0b op=%0d imm=%0d rd=%0d ra=%0d err=%0b rsv=%0b exp vld=1 op=%0d imm=%0d rd=%0d ra=%0d err=%0b rsv=%0b",
                  w[15:0], vld_o, op_o, $signed(imm_o), rd_o, ra_o, err_o, rsv_o,
                  op, imm, rd, ra, err, rsv));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk(!vld_o && op_o == 0 && imm_o == 0 && rd_o == 0 && ra_o == 0 && !err_o && !rsv_o,
        "R1", $sformatf("in reset act vld=%0b op=%0d imm=%0d exp all zero", vld_o, op_o, imm_o));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!vld_o && op_o == 0 && imm_o == 0 && rd_o == 0 && ra_o == 0 && !err_o && !rsv_o,
        "R1", $sformatf("after reset act vld=%0b op=%0d imm=%0d exp all zero", vld_o, op_o, imm_o));

    // exhaustive back-to-back sweep: R2, R4..R11
    valid_i = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      instr_i = 16'(i);
      @(negedge clk_i);
      chk_word(i);
    end

    // R3: idle cycles hold last result (0xFFFF) while input changes
    valid_i = 1'b0;
    instr_i = 16'h8001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(!vld_o && op_o == 5'd14 && $signed(imm_o) == -8 && rd_o == 7 && ra_o == 7 &&
          !err_o && !rsv_o, "R3",
          $sformatf("act vld=%0b op=%0d imm=%0d rd=%0d ra=%0d exp vld=0 op=14 imm=-8 rd=7 ra=7",
                    vld_o, op_o, $signed(imm_o), rd_o, ra_o));
      instr_i = instr_i + 16'h0102;
    end

    // R2: a single valid word after idle shows one cycle later
    valid_i = 1'b1;
    instr_i = 16'hC531;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk_word(32'hC531);
    @(negedge clk_i);
    chk(!vld_o, "R2", $sformatf("vld act=%0b exp=0", vld_o));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule